// File: doc/BRIEF.md
# Multi-Port Raster Sync Generator

This block is a free-running raster timing source for a display pipeline. A pixel counter steps once per pixel clock and wraps at a programmable line length. Each wrap advances a line counter, which wraps at a programmable field length. The line length and field length, together with the other settings, are held in a small word-addressed register file. Software writes and reads that file over a single-cycle bus.

The block drives several sync ports, four by default. Each port has its own horizontal pulse and its own vertical pulse. The vertical pulse edges are given as a line number plus a pixel offset within that line, so each downstream sink can be given timing that makes up for its own pipeline delay. The block also produces an active-picture flag from a rectangle set per field, a field flag, and one-cycle pulses that mark the start of a top field and the start of a bottom field.

The mode register selects one of three behaviours. In progressive mode every field is a top field. In alternating mode top and bottom fields take turns, and each uses its own vertical and window settings. Any other mode value freezes the counters. A restart command returns the raster to its origin.

Top module: `raster_sync_gen`

## Requirements
- R1: The pixel counter steps 0, 1, ... up to (line clocks − 1). At the end of the line it returns to 0 and the line number advances by one. Lines are numbered from 1, and the line after the last line of a field is line 1.
- R2: The field length is set by the half-line register at address 2. A field has floor(value/2) lines, so a progressive frame is programmed with twice its line count. The line-clocks register is at address 1.
- R3: Each port p has a horizontal register at address 8+8p. Its bits 15:0 are the start pixel and its bits 31:16 are the stop pixel. The port's hsync is high for start ≤ pixel < stop. If stop < start, hsync is high for pixel ≥ start or pixel < stop. If stop equals start, hsync never goes high.
- R4: Each port's vsync is high from its rise position up to, but not including, its fall position. Positions are ordered as (line, pixel) in raster order, and the window wraps across the field boundary when the fall position comes before the rise position. Line registers are at 8+8p+1 (top) and 8+8p+2 (bottom), and offset registers are at 8+8p+3 (top) and 8+8p+4 (bottom). In each of these registers, bits 15:0 hold the rise value and bits 31:16 hold the fall value.
- R5: While the field flag is 0 (top), vsync and the active flag use the top-field registers. While it is 1 (bottom), they use the bottom-field registers.
- R6: The active flag is high when the line lies between the begin line and end line inclusive and the pixel lies between the begin pixel and end pixel inclusive. Window words hold the line in bits 31:16 and the pixel in bits 15:0. The top begin/end words are at addresses 4/5 and the bottom begin/end words are at 6/7.
- R7: The mode register is at address 0. A value of 0 runs the counters with every field a top field. A value of 1 runs them with top and bottom fields alternating. Any other value freezes the pixel count, line count and field flag, and no field pulses are produced while frozen.
- R8: Writing a word with bit 0 set to address 3 puts the raster at pixel 0, line 1, top field on the next cycle. This works even while frozen. A write with bit 0 clear has no effect.
- R9: evt_top (or evt_bot) is high for exactly the cycle in which the raster is at pixel 0 of line 1 of a top (or bottom) field, and only while the counters run.
- R10: reg_rdata combinationally returns the register addressed by reg_addr. Address 3 and any unassigned address (for example 8+8p+5) read as 0, and writes to unassigned addresses are dropped.
- R11: After reset, the mode is 0, the line-clocks register is RST_LINE_CLKS, the half-line register is RST_HALF_LINES, and all other registers are 0. The raster starts at pixel 0, line 1, top field, and every sync and active output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one word per cycle |
| reg_addr | input | ADDR_W (6) | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| hsync | output | NUM_PORTS | Horizontal sync, one bit per port |
| vsync | output | NUM_PORTS | Vertical sync, one bit per port |
| active | output | 1 | Inside the active-picture window of the current field |
| field | output | 1 | Current field, 0 top and 1 bottom |
| evt_top | output | 1 | Start-of-top-field pulse |
| evt_bot | output | 1 | Start-of-bottom-field pulse |

## Verification
The cycle-level assertions check, on every cycle, how the counters move. A running pixel count either steps by one or returns to zero. A frozen raster holds its position and field. A restart lands on the origin. A field pulse never lasts two cycles, and progressive mode never leaves the top field. Only the bench scenarios can show the values the per-port pulses take: the horizontal and vertical windows with and without wrap, the empty window, the top versus bottom register sets, the inclusive active rectangle and the measured line and field periods. The bench compares every output on every cycle against an arithmetic raster position over whole frames.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
   localparam int unsigned WORD_W      = 32;
   localparam int unsigned HALF_W      = 16;

   // word addresses of the shared registers
   localparam int unsigned A_MODE      = 0;
   localparam int unsigned A_LINE_CLKS = 1;
   localparam int unsigned A_HALF_LNS  = 2;
   localparam int unsigned A_RESTART   = 3;
   localparam int unsigned A_WIN_BASE  = 4;
   localparam int unsigned WIN_REGS    = 4;

   // per-port register block
   localparam int unsigned A_PORT_BASE = 8;
   localparam int unsigned PORT_STRIDE = 8;
   localparam int unsigned PORT_REGS   = 5;
   localparam int unsigned P_HSYNC     = 0;
   localparam int unsigned P_VL_TOP    = 1;
   localparam int unsigned P_VL_BOT    = 2;
   localparam int unsigned P_VO_TOP    = 3;
   localparam int unsigned P_VO_BOT    = 4;

   // window word order inside the window block
   localparam int unsigned W_TOP_BEG   = 0;
   localparam int unsigned W_TOP_END   = 1;
   localparam int unsigned W_BOT_BEG   = 2;
   localparam int unsigned W_BOT_END   = 3;

   localparam logic [WORD_W-1:0] MODE_PROG = 32'd0;
   localparam logic [WORD_W-1:0] MODE_ALT  = 32'd1;
endpackage

// File: rtl/rsg_regs.sv
module rsg_regs
   import rsg_pkg::*;
#(
   parameter int unsigned NUM_PORTS      = 4,
   parameter int unsigned CNT_W          = 16,
   parameter int unsigned ADDR_W         = 6,
   parameter int unsigned RST_LINE_CLKS  = 16,
   parameter int unsigned RST_HALF_LINES = 16,
   localparam int unsigned PW            = 2 * CNT_W
)(
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        reg_wr,
   input  logic [ADDR_W-1:0]                           reg_addr,
   input  logic [WORD_W-1:0]                           reg_wdata,
   output logic [WORD_W-1:0]                           reg_rdata,
   output logic                                        run,
   output logic                                        alt,
   output logic                                        restart_req,
   output logic [CNT_W-1:0]                            line_clks,
   output logic [CNT_W-1:0]                            field_lines,
   output logic [WIN_REGS-1:0][PW-1:0]                 win,
   output logic [NUM_PORTS-1:0][PORT_REGS-1:0][PW-1:0] sync_cfg
);
   function automatic logic [PW-1:0] pack_pair(input logic [WORD_W-1:0] w);
      return {w[HALF_W +: CNT_W], w[0 +: CNT_W]};
   endfunction

   function automatic logic [WORD_W-1:0] unpack_pair(input logic [PW-1:0] p);
      logic [WORD_W-1:0] w;
      w = '0;
      w[HALF_W +: CNT_W] = p[CNT_W +: CNT_W];
      w[0 +: CNT_W]      = p[0 +: CNT_W];
      return w;
   endfunction

   logic [WORD_W-1:0] mode_q;
   logic [CNT_W-1:0]  half_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_PROG;
         line_clks <= CNT_W'(RST_LINE_CLKS);
         half_q    <= CNT_W'(RST_HALF_LINES);
         win       <= '0;
      end else if (reg_wr) begin
         if (reg_addr == ADDR_W'(A_MODE))      mode_q    <= reg_wdata;
         if (reg_addr == ADDR_W'(A_LINE_CLKS)) line_clks <= reg_wdata[CNT_W-1:0];
         if (reg_addr == ADDR_W'(A_HALF_LNS))  half_q    <= reg_wdata[CNT_W-1:0];
         for (int w = 0; w < WIN_REGS; w++)
            if (reg_addr == ADDR_W'(A_WIN_BASE + w)) win[w] <= pack_pair(reg_wdata);
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      for (genvar k = 0; k < PORT_REGS; k++) begin : g_reg
         localparam int unsigned ADR = A_PORT_BASE + PORT_STRIDE * p + k;
         logic [PW-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (reg_wr && reg_addr == ADDR_W'(ADR))
               q <= pack_pair(reg_wdata);
         end
         assign sync_cfg[p][k] = q;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(A_MODE))      reg_rdata = mode_q;
      if (reg_addr == ADDR_W'(A_LINE_CLKS)) reg_rdata = WORD_W'(line_clks);
      if (reg_addr == ADDR_W'(A_HALF_LNS))  reg_rdata = WORD_W'(half_q);
      for (int w = 0; w < WIN_REGS; w++)
         if (reg_addr == ADDR_W'(A_WIN_BASE + w)) reg_rdata = unpack_pair(win[w]);
      for (int p = 0; p < NUM_PORTS; p++)
         for (int k = 0; k < PORT_REGS; k++)
            if (reg_addr == ADDR_W'(A_PORT_BASE + PORT_STRIDE * p + k))
               reg_rdata = unpack_pair(sync_cfg[p][k]);
   end

   assign run         = (mode_q == MODE_PROG) || (mode_q == MODE_ALT);
   assign alt         = (mode_q == MODE_ALT);
   assign restart_req = reg_wr && (reg_addr == ADDR_W'(A_RESTART)) && reg_wdata[0];
   assign field_lines = {1'b0, half_q[CNT_W-1:1]};
endmodule

// File: rtl/rsg_raster.sv
module rsg_raster #(
   parameter int unsigned CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             alt,
   input  logic             restart_req,
   input  logic [CNT_W-1:0] line_clks,
   input  logic [CNT_W-1:0] field_lines,
   output logic [CNT_W-1:0] pix,
   output logic [CNT_W-1:0] line,
   output logic             field
);
   logic [CNT_W:0] pix_inc;
   logic           line_wrap;
   logic           field_wrap;

   assign pix_inc    = {1'b0, pix} + 1'b1;
   assign line_wrap  = pix_inc >= {1'b0, line_clks};
   assign field_wrap = line >= field_lines;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix   <= '0;
         line  <= CNT_W'(1);
         field <= 1'b0;
      end else if (restart_req) begin
         pix   <= '0;
         line  <= CNT_W'(1);
         field <= 1'b0;
      end else if (run) begin
         if (line_wrap) begin
            pix <= '0;
            if (field_wrap) begin
               line  <= CNT_W'(1);
               field <= alt ? ~field : 1'b0;
            end else begin
               line <= line + 1'b1;
            end
         end else begin
            pix <= pix_inc[CNT_W-1:0];
         end
      end
   end
endmodule

// File: rtl/rsg_span.sv
module rsg_span #(
   parameter int unsigned W = 16
)(
   input  logic [W-1:0] cur,
   input  logic [W-1:0] beg,
   input  logic [W-1:0] fin,
   output logic         hit
);
   always_comb begin
      if (beg <= fin)
         hit = (cur >= beg) && (cur < fin);
      else
         hit = (cur >= beg) || (cur < fin);
   end
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
   import rsg_pkg::*;
#(
   parameter int unsigned NUM_PORTS      = 4,
   parameter int unsigned CNT_W          = 16,
   parameter int unsigned RST_LINE_CLKS  = 16,
   parameter int unsigned RST_HALF_LINES = 16,
   localparam int unsigned ADDR_W        = $clog2(A_PORT_BASE + PORT_STRIDE * NUM_PORTS)
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [WORD_W-1:0]    reg_wdata,
   output logic [WORD_W-1:0]    reg_rdata,
   output logic [NUM_PORTS-1:0] hsync,
   output logic [NUM_PORTS-1:0] vsync,
   output logic                 active,
   output logic                 field,
   output logic                 evt_top,
   output logic                 evt_bot
);
   localparam int unsigned PW = 2 * CNT_W;

   if (NUM_PORTS < 1 || NUM_PORTS > 16) begin : g_bad_ports
      $error("raster_sync_gen: NUM_PORTS must lie in 1..16");
   end
   if (CNT_W < 2 || CNT_W > HALF_W) begin : g_bad_width
      $error("raster_sync_gen: CNT_W must lie in 2..16");
   end

   logic                                        run, alt, restart_req;
   logic [CNT_W-1:0]                            line_clks, field_lines;
   logic [WIN_REGS-1:0][PW-1:0]                 win;
   logic [NUM_PORTS-1:0][PORT_REGS-1:0][PW-1:0] sync_cfg;
   logic [CNT_W-1:0]                            pix, line;
   logic [PW-1:0]                               cur_pos;
   logic [PW-1:0]                               win_beg, win_end;
   logic                                        at_origin;

   rsg_regs #(
      .NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
      .RST_LINE_CLKS(RST_LINE_CLKS), .RST_HALF_LINES(RST_HALF_LINES)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .run(run), .alt(alt),
      .restart_req(restart_req), .line_clks(line_clks), .field_lines(field_lines),
      .win(win), .sync_cfg(sync_cfg)
   );

   rsg_raster #(.CNT_W(CNT_W)) u_raster (
      .clk(clk), .rst_n(rst_n), .run(run), .alt(alt), .restart_req(restart_req),
      .line_clks(line_clks), .field_lines(field_lines),
      .pix(pix), .line(line), .field(field)
   );

   assign cur_pos = {line, pix};

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sync
      logic [PW-1:0] hs_w, vl_w, vo_w;
      assign hs_w = sync_cfg[p][P_HSYNC];
      assign vl_w = field ? sync_cfg[p][P_VL_BOT] : sync_cfg[p][P_VL_TOP];
      assign vo_w = field ? sync_cfg[p][P_VO_BOT] : sync_cfg[p][P_VO_TOP];

      rsg_span #(.W(CNT_W)) u_hspan (
         .cur(pix), .beg(hs_w[CNT_W-1:0]), .fin(hs_w[PW-1:CNT_W]), .hit(hsync[p])
      );
      rsg_span #(.W(PW)) u_vspan (
         .cur(cur_pos),
         .beg({vl_w[CNT_W-1:0], vo_w[CNT_W-1:0]}),
         .fin({vl_w[PW-1:CNT_W], vo_w[PW-1:CNT_W]}),
         .hit(vsync[p])
      );
   end

   assign win_beg = field ? win[W_BOT_BEG] : win[W_TOP_BEG];
   assign win_end = field ? win[W_BOT_END] : win[W_TOP_END];
   assign active  = (line >= win_beg[PW-1:CNT_W]) && (line <= win_end[PW-1:CNT_W]) &&
                    (pix  >= win_beg[CNT_W-1:0])  && (pix  <= win_end[CNT_W-1:0]);

   assign at_origin = (pix == '0) && (line == CNT_W'(1));
   assign evt_top   = run && at_origin && !field;
   assign evt_bot   = run && at_origin && field;
endmodule

// File: rtl/rsg_chk.sv
module rsg_chk #(
   parameter int unsigned CNT_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             alt,
   input logic             restart_req,
   input logic [CNT_W-1:0] line_clks,
   input logic [CNT_W-1:0] pix,
   input logic [CNT_W-1:0] line,
   input logic             field,
   input logic             evt_top,
   input logic             evt_bot
);
   AST_RESTART_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |=> (pix == '0) && (line == CNT_W'(1)) && !field); // R8

   AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !restart_req) |=> (pix == $past(pix) + CNT_W'(1)) || (pix == '0)); // R1

   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart_req) |=> $stable(pix) && $stable(line) && $stable(field)); // R7

   AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_top && !restart_req && line_clks > CNT_W'(1)) |=> !evt_top && !evt_bot); // R9

   AST_PROG_STAYS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !alt && !field) |=> !field); // R7
endmodule

bind raster_sync_gen rsg_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .alt(alt), .restart_req(restart_req),
   .line_clks(line_clks), .pix(pix), .line(line), .field(field),
   .evt_top(evt_top), .evt_bot(evt_bot)
);

// File: tb/sim_raster_sync_gen.sv
module sim_raster_sync_gen;
   localparam int NP = 4;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [NP-1:0] hsync, vsync;
   logic          active, field, evt_top, evt_bot;

   always #2 clk = ~clk;

   raster_sync_gen #(.NUM_PORTS(NP), .CNT_W(16), .RST_LINE_CLKS(16), .RST_HALF_LINES(16)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync(hsync), .vsync(vsync),
      .active(active), .field(field), .evt_top(evt_top), .evt_bot(evt_bot)
   );

   int checks = 0;
   int fails  = 0;
   bit chk_on = 0;
   bit done   = 0;
   string phase = "sweep";

   // arithmetic raster model: cycles since the last restart
   int n = 0;
   int mode_m = 0;
   int cfg_c = 16, cfg_l = 8;
   int hb[NP], he[NP];
   int vrl[2][NP], vro[2][NP], vfl[2][NP], vfo[2][NP];
   int wbl[2], wbp[2], wel[2], wep[2];

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", tag, phase, act, exp, $time);
      end
   endtask

   function automatic bit span(input int c, input int b, input int e);
      if (b <= e) return (c >= b) && (c < e);
      return (c >= b) || (c < e);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         n <= 0;
         mode_m <= 0;
      end else begin
         if (reg_wr && reg_addr == AW'(3) && reg_wdata[0]) n <= 0;
         else if (mode_m == 0 || mode_m == 1) n <= n + 1;
         if (reg_wr && reg_addr == AW'(0)) mode_m <= int'(reg_wdata);
      end
   end

   always @(negedge clk) begin
      #1;
      if (chk_on && !done) begin
         int pix, ln, f, eh, ev, ea;
         bit runm;
         pix  = n % cfg_c;
         ln   = (n / cfg_c) % cfg_l + 1;
         f    = (mode_m == 1) ? (n / (cfg_c * cfg_l)) % 2 : 0;
         runm = (mode_m == 0) || (mode_m == 1);
         eh = 0;
         ev = 0;
         for (int p = 0; p < NP; p++) begin
            if (span(pix, hb[p], he[p])) eh |= (1 << p);
            if (span(ln * 65536 + pix, vrl[f][p] * 65536 + vro[f][p],
                     vfl[f][p] * 65536 + vfo[f][p])) ev |= (1 << p);
         end
         ea = (ln >= wbl[f] && ln <= wel[f] && pix >= wbp[f] && pix <= wep[f]) ? 1 : 0;
         check("R3 hsync ports", int'(hsync), eh);
         check("R4/R5 vsync ports", int'(vsync), ev);
         check("R6 active window", int'(active), ea);
         check("R7 field flag", int'(field), f);
         check("R9 top event", int'(evt_top), (runm && pix == 0 && ln == 1 && f == 0) ? 1 : 0);
         check("R9 bottom event", int'(evt_bot), (runm && pix == 0 && ln == 1 && f == 1) ? 1 : 0);
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_addr = AW'(a);
      reg_wdata = 32'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      reg_addr = AW'(a);
      #1;
      d = int'(reg_rdata);
   endtask

   task automatic cfg_hs(input int p, input int b, input int e);
      hb[p] = b;
      he[p] = e;
      wr(8 + 8 * p, (e << 16) | b);
   endtask

   task automatic cfg_vs(input int p, input int f, input int rl, input int ro, input int fl, input int fo);
      vrl[f][p] = rl; vro[f][p] = ro; vfl[f][p] = fl; vfo[f][p] = fo;
      wr(8 + 8 * p + 1 + f, (fl << 16) | rl);
      wr(8 + 8 * p + 3 + f, (fo << 16) | ro);
   endtask

   task automatic cfg_win(input int f, input int bl, input int bp, input int el, input int ep);
      wbl[f] = bl; wbp[f] = bp; wel[f] = el; wep[f] = ep;
      wr(4 + 2 * f, (bl << 16) | bp);
      wr(5 + 2 * f, (el << 16) | ep);
   endtask

   task automatic cfg_timing(input int c, input int halves);
      wr(1, c);
      wr(2, halves);
      cfg_c = c;
      cfg_l = halves / 2;
   endtask

   function automatic bit probe(input int which);
      return (which == 0) ? hsync[0] : evt_top;
   endfunction

   task automatic period_of(input int which, output int cyc);
      cyc = 0;
      do begin @(negedge clk); #1; end while (!probe(which));
      do begin @(negedge clk); #1; cyc++; end while (!probe(which));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         check("watchdog expired", 0, 1);
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int d, per;
      logic [NP-1:0] hs_snap, vs_snap;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11: reset state
      check("R11 hsync after reset", int'(hsync), 0);
      check("R11 vsync after reset", int'(vsync), 0);
      check("R11 active after reset", int'(active), 0);
      check("R11 field after reset", int'(field), 0);
      rd(0, d);  check("R11 mode reset", d, 0);
      rd(1, d);  check("R11 line clocks reset", d, 16);
      rd(2, d);  check("R11 half lines reset", d, 16);
      rd(8, d);  check("R11 port reg reset", d, 0);

      // R10: readback and unassigned addresses
      wr(16, 32'h0007_0003);   rd(16, d); check("R10 hsync readback", d, 32'h0007_0003);
      wr(5, 32'h0009_0011);    rd(5, d);  check("R10 window readback", d, 32'h0009_0011);
      wr(13, 32'h1234_5678);   rd(13, d); check("R10 unassigned reads zero", d, 0);
      wr(3, 1);                rd(3, d);  check("R10 restart reads zero", d, 0);
      wr(0, 7);                rd(0, d);  check("R10 mode readback", d, 7);
      wr(0, 0);

      // configuration A: progressive, 12 clocks x 6 lines
      cfg_timing(12, 12);
      cfg_hs(0, 0, 1);  cfg_hs(1, 3, 8);  cfg_hs(2, 10, 2);  cfg_hs(3, 5, 5);
      cfg_vs(0, 0, 1, 0, 2, 0);   cfg_vs(1, 0, 1, 5, 3, 5);
      cfg_vs(2, 0, 6, 9, 1, 9);   cfg_vs(3, 0, 2, 11, 4, 0);
      cfg_vs(0, 1, 3, 0, 4, 0);   cfg_vs(1, 1, 2, 2, 2, 7);
      cfg_vs(2, 1, 5, 0, 1, 0);   cfg_vs(3, 1, 1, 1, 1, 1);
      cfg_win(0, 2, 2, 5, 9);
      cfg_win(1, 1, 0, 1, 3);
      wr(3, 1);
      chk_on = 1;
      phase = "progressive sweep";
      repeat (216) @(negedge clk);

      period_of(0, per); check("R1 line period", per, 12);
      period_of(1, per); check("R2 field period", per, 72);

      // R8: a zero write to the restart address changes nothing
      phase = "R8 zero-write ignored";
      wr(3, 0);
      repeat (30) @(negedge clk);

      // R7: freeze, restart while frozen, resume
      phase = "R7 frozen";
      wr(0, 2);
      @(negedge clk); #1;
      hs_snap = hsync;
      vs_snap = vsync;
      repeat (10) @(negedge clk);
      #1;
      check("R7 hsync held while frozen", int'(hsync), int'(hs_snap));
      check("R7 vsync held while frozen", int'(vsync), int'(vs_snap));
      wr(3, 1);
      #1;
      check("R8 restart while frozen, no event", int'(evt_top), 0);
      repeat (5) @(negedge clk);
      phase = "resume";
      wr(0, 0);
      repeat (100) @(negedge clk);
      chk_on = 0;

      // configuration B: alternating fields, 10 clocks, odd half-line count
      cfg_timing(10, 11);
      wr(0, 1);
      wr(3, 1);
      chk_on = 1;
      phase = "alternating sweep";
      repeat (210) @(negedge clk);
      period_of(1, per); check("R2 odd half-line field pair period", per, 100);

      phase = "R8 restart in bottom field";
      do begin @(negedge clk); #1; end while (!field);
      repeat (7) @(negedge clk);
      wr(3, 1);
      #1;
      check("R8 restart field", int'(field), 0);
      check("R8 restart origin event", int'(evt_top), 1);
      repeat (120) @(negedge clk);
      chk_on = 0;

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule